// File: doc/BRIEF.md
# Digital Phase-Interpolator Clock Recovery Loop

This block is the digital loop filter of a clock-and-data-recovery receiver that steers its sampling clock with a phase interpolator. On each qualified update it takes one early/late vote from a bang-bang phase detector. It turns that vote into a proportional phase step and, in second-order mode, into a change of an integral (frequency) register. The sum drives a fixed-point phase accumulator, and the upper bits of that accumulator form a 7-bit interpolator code that wraps once per unit interval.

A configuration bit selects the loop order while the loop runs. In first-order mode the integral path is held at zero. That loop is always stable, but it keeps a standing phase error that grows with any frequency offset. In second-order mode the integral register learns the offset, and the standing error returns to near zero. The block also tracks the total phase moved since reset, counted in interpolator steps with wraps included. This total equals the drift of the recovered clock ticks against the nominal bit period. A lock-loss flag rises when the integral register sits at its limit for a programmable run of updates, which is the sign of an offset beyond the capture range.

Top module: `pi_cdr_loop`

## Requirements
- R1: After reset, piCode is 0, phaseShift is 0, freqState is 0 and lockLost is 0.
- R2: An update happens only on a clock edge where pdValid is 1. With pdValid at 0, piCode, phaseShift and lockLost keep their values. freqState also keeps its value while cfgSecondOrder is 1.
- R3: The phase vote is +1 when pdEarly=1 and pdLate=0, and −1 when pdLate=1 and pdEarly=0. It is 0 otherwise. Each update adds vote × (1024 >> cfgGpShift) to the phase accumulator, in units of 1/256 of an interpolator step. With cfgGpShift=2, one early vote moves piCode by +1.
- R4: In second-order mode (cfgSecondOrder=1), each update adds vote × (256 >> cfgGfShift) to freqState. It also adds the value that freqState held before the edge to the phase accumulator.
- R5: freqState is a signed 13-bit value that saturates at +4095 and −4096 and never wraps.
- R6: While cfgSecondOrder is 0, freqState is cleared to 0 on every edge and adds nothing to the accumulator.
- R7: piCode is accumulator bits [14:8] and wraps modulo 128 in both directions.
- R8: phaseShift is a signed 23-bit value equal to 128 × (signed wrap count) + piCode. This is the floor of the total accumulator movement since reset divided by 256.
- R9: On each update, a run counter that saturates at 255 increments when the new freqState is +4095 or −4096 in second-order mode. Otherwise it resets to 0. lockLost is 1 exactly when cfgLossLimit is not 0 and the run count is at least cfgLossLimit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdValid | input | 1 | Qualifies one phase-detector update |
| pdEarly | input | 1 | Early vote |
| pdLate | input | 1 | Late vote |
| cfgSecondOrder | input | 1 | 1 = second-order loop, 0 = first-order |
| cfgGpShift | input | 4 | Right shift applied to the proportional step |
| cfgGfShift | input | 4 | Right shift applied to the integral step |
| cfgLossLimit | input | 8 | Saturated-update run that raises lockLost (0 disables the flag) |
| piCode | output | 7 | Phase-interpolator code |
| freqState | output | 13 | Signed integral (frequency) register |
| phaseShift | output | 23 | Signed total phase moved since reset, in code steps |
| lockLost | output | 1 | Integral path held at saturation too long |

## Verification
The assertions assume that cfgLossLimit stays steady around a decision edge. They also assume that no single correction reaches half the accumulator range, which holds for every legal shift and the 13-bit integral width. The bench changes configuration only on falling edges between update groups. It drives votes as runs of early, late, idle, both-high and invalid cycles, so that wraps in both directions, saturation at the positive limit, release from it, and switching the loop order all occur within the allowed input space.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic doUpdate;     // accumulate this cycle
    logic doIntegrate;  // integral path active this cycle
    logic clrFreq;      // hold integral register at zero
    logic stepUp;       // vote +1
    logic stepDown;     // vote -1
  } loopStrobe_t;
endpackage

// File: rtl/cdr_ctrl.sv
module cdr_ctrl
  import cdr_pkg::*;
#(
  parameter int LOSS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdValid,
  input  logic              pdEarly,
  input  logic              pdLate,
  input  logic              cfgSecondOrder,
  input  logic [LOSS_W-1:0] cfgLossLimit,
  input  logic              freqSatNext,
  output loopStrobe_t       strobe,
  output logic              lockLost
);
  localparam logic [LOSS_W-1:0] RUN_MAX = {LOSS_W{1'b1}};

  logic [LOSS_W-1:0] satRun;

  always_comb begin
    strobe.doUpdate    = pdValid;
    strobe.doIntegrate = pdValid && cfgSecondOrder;
    strobe.clrFreq     = !cfgSecondOrder;
    strobe.stepUp      = pdValid && pdEarly && !pdLate;
    strobe.stepDown    = pdValid && pdLate && !pdEarly;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      satRun <= '0;
    end else if (pdValid) begin
      if (freqSatNext) begin
        if (satRun != RUN_MAX) satRun <= satRun + 1'b1;
      end else begin
        satRun <= '0;
      end
    end
  end

  assign lockLost = (cfgLossLimit != '0) && (satRun >= cfgLossLimit);

  // R9
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdValid && !freqSatNext && $stable(cfgLossLimit)) |=> (!lockLost || cfgLossLimit == '0));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pdValid && $stable(cfgLossLimit)) |=> $stable(lockLost));
endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import cdr_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int FRAC_W   = 8,
  parameter int FREQ_W   = 13,
  parameter int WRAP_W   = 16,
  parameter int SHIFT_W  = 4,
  parameter int PROP_LOG = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  loopStrobe_t                strobe,
  input  logic [SHIFT_W-1:0]         cfgGpShift,
  input  logic [SHIFT_W-1:0]         cfgGfShift,
  output logic                       freqSatNext,
  output logic [CODE_W-1:0]          piCode,
  output logic signed [FREQ_W-1:0]   freqState,
  output logic signed [WRAP_W+CODE_W-1:0] phaseShift
);
  localparam int ACC_W = CODE_W + FRAC_W;
  localparam int SUM_W = ACC_W + 2;
  localparam int FX_W  = FREQ_W + 1;
  localparam logic [ACC_W-1:0]  PROP_ONE = ACC_W'(1) << (FRAC_W + PROP_LOG);
  localparam logic [FREQ_W-1:0] FREQ_ONE = FREQ_W'(1) << FRAC_W;
  localparam logic signed [FX_W-1:0] FMAX = $signed(FX_W'((1 << (FREQ_W-1)) - 1));
  localparam logic signed [FX_W-1:0] FMIN = -FMAX - 1;

  logic [ACC_W-1:0]          accReg;
  logic signed [FREQ_W-1:0]  freqReg;
  logic signed [WRAP_W-1:0]  wrapCnt;

  logic [ACC_W-1:0]          propMag;
  logic [FREQ_W-1:0]         freqMag;
  logic signed [SUM_W-1:0]   propTerm, freqTerm, corr, sumExt;
  logic signed [FX_W-1:0]    freqStep, freqSum, freqNext;
  logic                      wrapUp, wrapDown;

  always_comb begin
    propMag  = PROP_ONE >> cfgGpShift;
    freqMag  = FREQ_ONE >> cfgGfShift;
    propTerm = strobe.stepUp   ?  $signed(SUM_W'(propMag)) :
               strobe.stepDown ? -$signed(SUM_W'(propMag)) : '0;
    freqTerm = strobe.doIntegrate ?
               $signed({{(SUM_W-FREQ_W){freqReg[FREQ_W-1]}}, freqReg}) : '0;
    corr     = propTerm + freqTerm;
    sumExt   = $signed({2'b00, accReg}) + corr;
    wrapDown = sumExt[SUM_W-1];
    wrapUp   = !sumExt[SUM_W-1] && sumExt[ACC_W];

    freqStep = strobe.stepUp   ?  $signed(FX_W'(freqMag)) :
               strobe.stepDown ? -$signed(FX_W'(freqMag)) : '0;
    freqSum  = $signed({freqReg[FREQ_W-1], freqReg}) + freqStep;
    if (freqSum > FMAX)      freqNext = FMAX;
    else if (freqSum < FMIN) freqNext = FMIN;
    else                     freqNext = freqSum;
    freqSatNext = strobe.doIntegrate && (freqNext == FMAX || freqNext == FMIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      freqReg <= '0;
      wrapCnt <= '0;
    end else begin
      if (strobe.doUpdate) begin
        accReg <= sumExt[ACC_W-1:0];
        if (wrapUp)        wrapCnt <= wrapCnt + 1'b1;
        else if (wrapDown) wrapCnt <= wrapCnt - 1'b1;
      end
      if (strobe.clrFreq)          freqReg <= '0;
      else if (strobe.doIntegrate) freqReg <= freqNext[FREQ_W-1:0];
    end
  end

  assign piCode     = accReg[ACC_W-1 -: CODE_W];
  assign freqState  = freqReg;
  assign phaseShift = $signed({wrapCnt, piCode});

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doUpdate |=> $stable(phaseShift));

  // R8
  shift_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doUpdate && !corr[SUM_W-1]) |=> (phaseShift >= $past(phaseShift)));

  // R5
  freq_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doIntegrate && !strobe.clrFreq && freqReg == FMAX[FREQ_W-1:0] && !strobe.stepDown)
      |=> (freqState == FMAX[FREQ_W-1:0]));

  // R6
  freq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.clrFreq) |=> (freqState == '0));
endmodule

// File: rtl/pi_cdr_loop.sv
module pi_cdr_loop
  import cdr_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int FRAC_W  = 8,
  parameter int FREQ_W  = 13,
  parameter int WRAP_W  = 16,
  parameter int SHIFT_W = 4,
  parameter int LOSS_W  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            pdValid,
  input  logic                            pdEarly,
  input  logic                            pdLate,
  input  logic                            cfgSecondOrder,
  input  logic [SHIFT_W-1:0]              cfgGpShift,
  input  logic [SHIFT_W-1:0]              cfgGfShift,
  input  logic [LOSS_W-1:0]               cfgLossLimit,
  output logic [CODE_W-1:0]               piCode,
  output logic signed [FREQ_W-1:0]        freqState,
  output logic signed [WRAP_W+CODE_W-1:0] phaseShift,
  output logic                            lockLost
);
  loopStrobe_t strobe;
  logic        freqSatNext;

  cdr_ctrl #(.LOSS_W(LOSS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pdValid(pdValid), .pdEarly(pdEarly), .pdLate(pdLate),
    .cfgSecondOrder(cfgSecondOrder), .cfgLossLimit(cfgLossLimit),
    .freqSatNext(freqSatNext), .strobe(strobe), .lockLost(lockLost)
  );

  cdr_datapath #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W),
    .WRAP_W(WRAP_W), .SHIFT_W(SHIFT_W), .PROP_LOG(2)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgGpShift(cfgGpShift), .cfgGfShift(cfgGfShift),
    .freqSatNext(freqSatNext), .piCode(piCode),
    .freqState(freqState), .phaseShift(phaseShift)
  );
endmodule

// File: tb/tb_pi_cdr_loop.sv
`timescale 1ns/1ps
module tb_pi_cdr_loop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdValid = 1'b0, pdEarly = 1'b0, pdLate = 1'b0;
  logic cfgSecondOrder = 1'b0;
  logic [3:0] cfgGpShift = 4'd2, cfgGfShift = 4'd4;
  logic [7:0] cfgLossLimit = 8'd0;
  logic [6:0] piCode;
  logic signed [12:0] freqState;
  logic signed [22:0] phaseShift;
  logic lockLost;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int code; int freq; longint shift; bit lock; string req;
  } exp_t;
  exp_t sb[$];

  // reference model state
  longint mTotal = 0;
  int mFreq = 0, mRun = 0;

  always #2 clk = ~clk;

  pi_cdr_loop dut (
    .clk(clk), .rstN(rstN), .pdValid(pdValid), .pdEarly(pdEarly), .pdLate(pdLate),
    .cfgSecondOrder(cfgSecondOrder), .cfgGpShift(cfgGpShift), .cfgGfShift(cfgGfShift),
    .cfgLossLimit(cfgLossLimit), .piCode(piCode), .freqState(freqState),
    .phaseShift(phaseShift), .lockLost(lockLost)
  );

  function automatic int clampF(int v);
    if (v > 4095) return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (piCode !== e.code[6:0] || freqState !== e.freq[12:0] ||
        longint'(phaseShift) != e.shift || lockLost !== e.lock) begin
      errors++;
      $display("FAIL %s: code=%0d freq=%0d shift=%0d lock=%0b expected code=%0d freq=%0d shift=%0d lock=%0b",
               e.req, piCode, freqState, phaseShift, lockLost, e.code, e.freq, e.shift, e.lock);
    end
  endtask

  // driver: one cycle, model update, push expectation
  task automatic drive(bit v, bit e, bit l, string req);
    exp_t x;
    int d;
    @(negedge clk);
    pdValid = v; pdEarly = e; pdLate = l;
    d = (e && !l) ? 1 : (l && !e) ? -1 : 0;
    if (v) begin
      int nf;
      mTotal += longint'(d * (1024 >> cfgGpShift)) + (cfgSecondOrder ? longint'(mFreq) : 0);
      nf = cfgSecondOrder ? clampF(mFreq + d * (256 >> cfgGfShift)) : 0;
      if (cfgSecondOrder && (nf == 4095 || nf == -4096)) mRun = (mRun < 255) ? mRun + 1 : 255;
      else mRun = 0;
      mFreq = nf;
    end else if (!cfgSecondOrder) begin
      mFreq = 0;
    end
    x.shift = mTotal >>> 8;
    x.code  = int'(x.shift & 127);
    x.freq  = mFreq;
    x.lock  = (cfgLossLimit != 0) && (mRun >= int'(cfgLossLimit));
    x.req   = req;
    sb.push_back(x);
  endtask

  task automatic cfg(bit so, int gp, int gf, int lim);
    @(negedge clk);
    pdValid = 0;
    cfgSecondOrder = so; cfgGpShift = 4'(gp); cfgGfShift = 4'(gf); cfgLossLimit = 8'(lim);
    if (!so) mFreq = 0;
    // this idle edge is also scored
    begin
      exp_t x;
      x.shift = mTotal >>> 8; x.code = int'(x.shift & 127); x.freq = mFreq;
      x.lock = (lim != 0) && (mRun >= lim); x.req = "R6";
      sb.push_back(x);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  // watchdog
  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (piCode !== 0 || freqState !== 0 || phaseShift !== 0 || lockLost !== 0) begin
      errors++;
      $display("FAIL R1: code=%0d freq=%0d shift=%0d lock=%0b expected all 0",
               piCode, freqState, phaseShift, lockLost);
    end
    rstN = 1'b1;

    // R3 first order proportional steps
    for (int i = 0; i < 5; i++) drive(1, 1, 0, "R3");
    for (int i = 0; i < 3; i++) drive(1, 0, 1, "R3");
    // R2 invalid votes and void votes hold state
    for (int i = 0; i < 4; i++) drive(0, 1, 0, "R2");
    drive(1, 1, 1, "R2");
    drive(1, 0, 0, "R2");
    // R7 wrap downwards then upwards
    for (int i = 0; i < 135; i++) drive(1, 0, 1, "R7");
    for (int i = 0; i < 270; i++) drive(1, 1, 0, "R7");
    // R3 smaller and vanishing gains
    cfg(0, 5, 4, 0);
    for (int i = 0; i < 20; i++) drive(1, 0, 1, "R3");
    cfg(0, 11, 4, 0);
    for (int i = 0; i < 6; i++) drive(1, 1, 0, "R3");

    // R4 second order integration
    cfg(1, 2, 4, 4);
    for (int i = 0; i < 10; i++) drive(1, 1, 0, "R4");
    for (int i = 0; i < 4; i++) drive(0, 1, 0, "R2");
    for (int i = 0; i < 6; i++) drive(1, 0, 0, "R4");
    for (int i = 0; i < 25; i++) drive(1, 0, 1, "R4");
    for (int i = 0; i < 8; i++) drive(1, i % 2 == 0, i % 2 == 1, "R8");

    // R5/R9 saturation and lock loss
    cfg(1, 2, 0, 4);
    for (int i = 0; i < 30; i++) drive(1, 1, 0, "R5");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, "R9");
    drive(1, 0, 1, "R9");
    for (int i = 0; i < 6; i++) drive(1, 1, 0, "R9");
    cfg(1, 2, 0, 0);
    drive(1, 1, 0, "R9");

    // R6 order switch clears integral
    cfg(0, 2, 0, 4);
    for (int i = 0; i < 5; i++) drive(1, 1, 0, "R6");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, "R6");

    repeat (3) @(negedge clk);
    pdValid = 0;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule